// File: doc/BRIEF.md
# DMA Address Fence and Fill-Level Monitor

This block watches the running address pointer of one DMA channel. It compares the pointer against a programmed fence address. When the pointer crosses the fence, the block halts the channel and applies one of three recovery policies. The policy comes from a drain-control bit and a 4-bit limit code:

- **Skip:** idle until the window ends.
- **Drain:** lock the FIFO input, wait for the FIFO to empty, then clear the channel enable. This gives a one-shot capture.
- **Ring:** ask the address generator to reload the pointer from the base address, so the buffer runs as a continuous ring.

Independently, a nonzero limit code makes the block pulse a fill-level interrupt each time an advanced pointer lands on a 2^(5+L)-byte boundary. Software can use this to follow the buffer's fill level.

The address generator sits beside this block. It drives the current pointer, presenting each freshly advanced value together with a one-cycle step strobe. It also consumes the stop, lock, reload and enable-clear controls. Every output is registered. Each output reflects the inputs of the previous clock cycle.

Top module: `addr_fence_monitor`

## Requirements
- R1: While the channel is enabled and not already stopped, a fence violation sets stop_xfer in the next cycle. With neg_pitch=0, a violation is ptr >= fence_addr. With neg_pitch=1, it is ptr <= fence_addr.
- R2: fence_irq is a one-cycle pulse on a violation. There is no pulse when the violation already held in the cycle chan_en rose. There is also no pulse for a violation that persists after one has been reported.
- R3: With drain_mode=0 and limit_code=0, a violation enters skip. In skip, stop_xfer stays high until window_end is seen, and it is low from the following cycle.
- R4: With drain_mode=1, a violation raises lock_in and stop_xfer. When fifo_empty is seen, en_clear pulses for one cycle. stop_xfer and lock_in then stay high until chan_en goes low.
- R5: With drain_mode=0 and a nonzero limit_code, a violation pulses reload_ptr for one cycle, and in the same cycle reload_addr carries base_addr. stop_xfer stays high until the pointer no longer violates.
- R6: drain_mode=1 selects draining regardless of limit_code.
- R7: Let L be a nonzero limit_code. A ptr_step whose ptr has bits [4+L:0] all zero pulses limit_irq in the next cycle. With L=0, limit_irq never pulses.
- R8: A channel enabled with its pointer at a base_addr equal to fence_addr is stopped at once without a fence_irq.
- R9: When chan_en is low, the next cycle has stop_xfer, lock_in, en_clear, reload_ptr and fence_irq all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| chan_en | input | 1 | Channel enable |
| drain_mode | input | 1 | 1 selects drain-and-disable handling |
| limit_code | input | LW (4) | Boundary code L; nonzero selects ring mode and fill interrupts |
| neg_pitch | input | 1 | 1 mirrors the fence comparison |
| ptr | input | AW (32) | Current transfer address |
| ptr_step | input | 1 | Pointer has just advanced to the value on ptr |
| base_addr | input | AW (32) | Buffer start address used for reload |
| fence_addr | input | AW (32) | Protection address |
| window_end | input | 1 | End of the current window |
| fifo_empty | input | 1 | Channel FIFO is empty |
| stop_xfer | output | 1 | Transfers halted |
| lock_in | output | 1 | FIFO input locked |
| reload_ptr | output | 1 | One-cycle request to load reload_addr into the pointer |
| reload_addr | output | AW (32) | Address to reload |
| en_clear | output | 1 | One-cycle request to clear the channel enable |
| fence_irq | output | 1 | Violation interrupt pulse |
| limit_irq | output | 1 | Boundary interrupt pulse |

## Verification
The hardest case to reach is the interrupt suppression. The violation must already hold in the exact cycle chan_en rises. Only then does the block stop without reporting.

The stimulus first parks the enable low. It then sets the pointer, base and fence to one equal value, and only afterwards raises the enable. The bench also repeats the drain sequence with a nonzero limit code and a held-off fifo_empty. This shows that draining outranks ring reload, and that the halt holds until the enable drops.

// File: rtl/afm_pkg.sv
package afm_pkg;

  typedef enum logic [2:0] {
    ST_RUN    = 3'd0,
    ST_SKIP   = 3'd1,
    ST_DRAIN  = 3'd2,
    ST_HALT   = 3'd3,
    ST_RELOAD = 3'd4
  } guard_state_t;

  typedef enum logic [1:0] {
    POL_SKIP  = 2'd0,
    POL_DRAIN = 2'd1,
    POL_RING  = 2'd2
  } policy_t;

  function automatic policy_t pick_policy(input logic drain, input logic code_nz);
    if (drain)        return POL_DRAIN;
    else if (code_nz) return POL_RING;
    else              return POL_SKIP;
  endfunction

endpackage

// File: rtl/afm_cmp.sv
module afm_cmp #(
  parameter int AW = 32
) (
  input  logic [AW-1:0] ptr,
  input  logic [AW-1:0] fence_addr,
  input  logic          neg_pitch,
  output logic          over
);
  logic ge, le;

  always_comb begin
    ge   = (ptr >= fence_addr);
    le   = (ptr <= fence_addr);
    over = neg_pitch ? le : ge;
  end
endmodule

// File: rtl/afm_boundary.sv
module afm_boundary #(
  parameter int AW      = 32,
  parameter int LW      = 4,
  parameter int LB_BASE = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          chan_en,
  input  logic          ptr_step,
  input  logic [AW-1:0] ptr,
  input  logic [LW-1:0] limit_code,
  output logic          limit_irq
);
  localparam int NCODE = 1 << LW;

  logic [NCODE-1:0] aligned;

  assign aligned[0] = 1'b0;

  genvar c;
  generate
    for (c = 1; c < NCODE; c++) begin : g_code
      assign aligned[c] = (ptr[LB_BASE+c-1:0] == '0);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) limit_irq <= 1'b0;
    else     limit_irq <= chan_en & ptr_step & aligned[limit_code];
  end
endmodule

// File: rtl/afm_ctrl.sv
module afm_ctrl
  import afm_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          chan_en,
  input  logic          over,
  input  policy_t       policy,
  input  logic          window_end,
  input  logic          fifo_empty,
  input  logic [AW-1:0] base_addr,
  output logic          stop_xfer,
  output logic          lock_in,
  output logic          reload_ptr,
  output logic [AW-1:0] reload_addr,
  output logic          en_clear,
  output logic          fence_irq
);
  guard_state_t st, st_nx;
  logic         en_q, armed, armed_nx;
  logic         fire, rise;

  always_comb begin
    rise  = chan_en & ~en_q;
    fire  = chan_en & (st == ST_RUN) & over;
    st_nx = st;
    if (!chan_en) begin
      st_nx = ST_RUN;
    end else begin
      unique case (st)
        ST_RUN: if (over) begin
          unique case (policy)
            POL_DRAIN: st_nx = ST_DRAIN;
            POL_RING:  st_nx = ST_RELOAD;
            default:   st_nx = ST_SKIP;
          endcase
        end
        ST_SKIP:   if (window_end) st_nx = ST_RUN;
        ST_DRAIN:  if (fifo_empty) st_nx = ST_HALT;
        ST_HALT:   st_nx = ST_HALT;
        ST_RELOAD: if (!over) st_nx = ST_RUN;
        default:   st_nx = ST_RUN;
      endcase
    end

    if (!chan_en)  armed_nx = 1'b0;
    else if (rise) armed_nx = ~over;
    else if (fire) armed_nx = 1'b0;
    else if (!over) armed_nx = 1'b1;
    else           armed_nx = armed;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st          <= ST_RUN;
      en_q        <= 1'b0;
      armed       <= 1'b0;
      stop_xfer   <= 1'b0;
      lock_in     <= 1'b0;
      reload_ptr  <= 1'b0;
      reload_addr <= '0;
      en_clear    <= 1'b0;
      fence_irq   <= 1'b0;
    end else begin
      st         <= st_nx;
      en_q       <= chan_en;
      armed      <= armed_nx;
      stop_xfer  <= (st_nx != ST_RUN);
      lock_in    <= (st_nx == ST_DRAIN) | (st_nx == ST_HALT);
      fence_irq  <= fire & armed & ~rise;
      reload_ptr <= fire & (policy == POL_RING);
      en_clear   <= chan_en & (st == ST_DRAIN) & fifo_empty;
      if (fire && policy == POL_RING) reload_addr <= base_addr;
    end
  end
endmodule

// File: rtl/addr_fence_monitor.sv
module addr_fence_monitor
  import afm_pkg::*;
#(
  parameter int AW      = 32,
  parameter int LW      = 4,
  parameter int LB_BASE = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          chan_en,
  input  logic          drain_mode,
  input  logic [LW-1:0] limit_code,
  input  logic          neg_pitch,
  input  logic [AW-1:0] ptr,
  input  logic          ptr_step,
  input  logic [AW-1:0] base_addr,
  input  logic [AW-1:0] fence_addr,
  input  logic          window_end,
  input  logic          fifo_empty,
  output logic          stop_xfer,
  output logic          lock_in,
  output logic          reload_ptr,
  output logic [AW-1:0] reload_addr,
  output logic          en_clear,
  output logic          fence_irq,
  output logic          limit_irq
);
  logic    over;
  policy_t policy;

  assign policy = pick_policy(drain_mode, |limit_code);

  afm_cmp #(.AW(AW)) u_cmp (
    .ptr        (ptr),
    .fence_addr (fence_addr),
    .neg_pitch  (neg_pitch),
    .over       (over)
  );

  afm_boundary #(.AW(AW), .LW(LW), .LB_BASE(LB_BASE)) u_bnd (
    .clk        (clk),
    .rst        (rst),
    .chan_en    (chan_en),
    .ptr_step   (ptr_step),
    .ptr        (ptr),
    .limit_code (limit_code),
    .limit_irq  (limit_irq)
  );

  afm_ctrl #(.AW(AW)) u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .chan_en     (chan_en),
    .over        (over),
    .policy      (policy),
    .window_end  (window_end),
    .fifo_empty  (fifo_empty),
    .base_addr   (base_addr),
    .stop_xfer   (stop_xfer),
    .lock_in     (lock_in),
    .reload_ptr  (reload_ptr),
    .reload_addr (reload_addr),
    .en_clear    (en_clear),
    .fence_irq   (fence_irq)
  );
endmodule

// File: rtl/addr_fence_monitor_chk.sv
module addr_fence_monitor_chk #(
  parameter int AW = 32,
  parameter int LW = 4
) (
  input logic          clk,
  input logic          rst,
  input logic          chan_en,
  input logic          fifo_empty,
  input logic [LW-1:0] limit_code,
  input logic          ptr_step,
  input logic          stop_xfer,
  input logic          lock_in,
  input logic          reload_ptr,
  input logic          en_clear,
  input logic          fence_irq,
  input logic          limit_irq
);
  // R4
  lock_implies_stop_chk: assert property (@(posedge clk) disable iff (rst)
    lock_in |-> stop_xfer);

  // R4
  clear_after_empty_chk: assert property (@(posedge clk) disable iff (rst)
    en_clear |-> ($past(fifo_empty) && $past(lock_in) && lock_in));

  // R2
  irq_from_running_chk: assert property (@(posedge clk) disable iff (rst)
    fence_irq |-> ($past(chan_en) && !$past(stop_xfer) && stop_xfer));

  // R5
  reload_stops_chk: assert property (@(posedge clk) disable iff (rst)
    reload_ptr |-> (stop_xfer && !lock_in));

  // R7
  limit_needs_step_chk: assert property (@(posedge clk) disable iff (rst)
    limit_irq |-> ($past(ptr_step) && $past(limit_code) != '0));

  // R9
  idle_when_off_chk: assert property (@(posedge clk) disable iff (rst)
    !chan_en |=> (!stop_xfer && !lock_in && !en_clear && !reload_ptr && !fence_irq));

  // R4
  one_action_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({en_clear, reload_ptr}));
endmodule

bind addr_fence_monitor addr_fence_monitor_chk #(.AW(AW), .LW(LW)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .chan_en    (chan_en),
  .fifo_empty (fifo_empty),
  .limit_code (limit_code),
  .ptr_step   (ptr_step),
  .stop_xfer  (stop_xfer),
  .lock_in    (lock_in),
  .reload_ptr (reload_ptr),
  .en_clear   (en_clear),
  .fence_irq  (fence_irq),
  .limit_irq  (limit_irq)
);

// File: tb/addr_fence_monitor_test.sv
module addr_fence_monitor_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        chan_en = 0, drain_mode = 0, neg_pitch = 0, ptr_step = 0;
  logic        window_end = 0, fifo_empty = 0;
  logic [3:0]  limit_code = 0;
  logic [31:0] ptr = 0, base_addr = 0, fence_addr = 32'h1000;
  logic        stop_xfer, lock_in, reload_ptr, en_clear, fence_irq, limit_irq;
  logic [31:0] reload_addr;

  int errors = 0;
  int checks = 0;

  always #10 clk = ~clk;

  addr_fence_monitor uut (
    .clk(clk), .rst(rst), .chan_en(chan_en), .drain_mode(drain_mode),
    .limit_code(limit_code), .neg_pitch(neg_pitch), .ptr(ptr), .ptr_step(ptr_step),
    .base_addr(base_addr), .fence_addr(fence_addr), .window_end(window_end),
    .fifo_empty(fifo_empty), .stop_xfer(stop_xfer), .lock_in(lock_in),
    .reload_ptr(reload_ptr), .reload_addr(reload_addr), .en_clear(en_clear),
    .fence_irq(fence_irq), .limit_irq(limit_irq)
  );

  // Behavioural reference: phase 0 run, 1 skip, 2 drain, 3 halted, 4 awaiting reload
  int          phase = 0;
  bit          m_armed = 0, m_prev_en = 0;
  bit          e_stop = 0, e_lock = 0, e_reload = 0, e_clear = 0, e_firq = 0, e_lirq = 0;
  logic [31:0] e_raddr = 0;

  always @(posedge clk) begin
    if (rst) begin
      phase = 0; m_armed = 0; m_prev_en = 0;
      e_stop = 0; e_lock = 0; e_reload = 0; e_clear = 0; e_firq = 0; e_lirq = 0;
      e_raddr = 0;
    end else begin
      bit viol, newly_on, armed_now;
      longint unsigned span;
      viol     = neg_pitch ? (ptr <= fence_addr) : (ptr >= fence_addr);
      newly_on = chan_en && !m_prev_en;
      armed_now = m_armed;
      e_reload = 0; e_clear = 0; e_firq = 0;
      e_lirq = 0;
      if (chan_en && ptr_step && limit_code != 0) begin
        span = longint'(1) << (5 + limit_code);
        e_lirq = ((longint'(ptr) % span) == 0);
      end
      if (!chan_en) begin
        phase = 0; m_armed = 0;
      end else begin
        if (newly_on) m_armed = !viol;
        else if (!viol) m_armed = 1;
        case (phase)
          0: if (viol) begin
               e_firq = armed_now && !newly_on;
               m_armed = 0;
               if (drain_mode) phase = 2;
               else if (limit_code == 0) phase = 1;
               else begin phase = 4; e_reload = 1; e_raddr = base_addr; end
             end
          1: if (window_end) phase = 0;
          2: if (fifo_empty) begin e_clear = 1; phase = 3; end
          4: if (!viol) phase = 0;
          default: ;
        endcase
      end
      m_prev_en = chan_en;
      e_stop = (phase != 0);
      e_lock = (phase == 2) || (phase == 3);
    end
  end

  task automatic chk(input logic got, input logic exp, input string tag);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0b expected %0b at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic chk32(input logic [31:0] got, input logic [31:0] exp, input string tag);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      chk(stop_xfer,  e_stop,   "R1 stop_xfer");
      chk(lock_in,    e_lock,   "R4 lock_in");
      chk(en_clear,   e_clear,  "R4 en_clear");
      chk(fence_irq,  e_firq,   "R2 fence_irq");
      chk(reload_ptr, e_reload, "R5 reload_ptr");
      chk(limit_irq,  e_lirq,   "R7 limit_irq");
      if (e_reload) chk32(reload_addr, e_raddr, "R5 reload_addr");
    end
  end

  task automatic cyc(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic step_to(input logic [31:0] a);
    ptr = a; ptr_step = 1;
    cyc();
    ptr_step = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got hung expected finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    cyc(3);
    chk(stop_xfer, 0, "R9 reset stop"); chk(fence_irq, 0, "R2 reset irq");
    rst = 0;
    cyc();
    // R7: boundary interrupts at several codes
    chan_en = 1; limit_code = 1; drain_mode = 0;
    cyc();
    for (int i = 1; i <= 6; i++) step_to(32'h40 * i);
    limit_code = 2;
    for (int i = 7; i <= 12; i++) step_to(32'h40 * i);
    chk(limit_irq, 1, "R7 code2 at 0x300 pulse");
    step_to(32'h320);
    chk(limit_irq, 0, "R7 unaligned no pulse");
    limit_code = 0;
    step_to(32'h400);
    chk(limit_irq, 0, "R7 code0 never");
    // R1 R2 R3: skip mode
    step_to(32'h1000);
    chk(stop_xfer, 1, "R1 stop on reach"); chk(fence_irq, 1, "R2 irq pulse");
    cyc();
    chk(fence_irq, 0, "R2 single pulse"); chk(stop_xfer, 1, "R3 held");
    ptr = 32'h100; cyc(3);
    chk(stop_xfer, 1, "R3 still waiting");
    window_end = 1; cyc(); window_end = 0;
    chk(stop_xfer, 0, "R3 resume after window end");
    // R5 ring mode
    limit_code = 3; base_addr = 32'h200;
    step_to(32'h1040);
    chk(reload_ptr, 1, "R5 reload pulse"); chk32(reload_addr, 32'h200, "R5 base value");
    cyc(2);
    chk(stop_xfer, 1, "R5 held until pointer moves");
    ptr = 32'h200; cyc();
    chk(stop_xfer, 0, "R5 released");
    cyc();
    // R4 R6 drain outranks nonzero limit
    drain_mode = 1;
    step_to(32'h1000);
    chk(lock_in, 1, "R6 drain chosen"); chk(reload_ptr, 0, "R6 no reload");
    cyc(3);
    fifo_empty = 1; cyc(); fifo_empty = 0;
    chk(en_clear, 1, "R4 enable clear");
    cyc(3);
    chk(stop_xfer, 1, "R4 halted"); chk(en_clear, 0, "R4 single clear");
    chan_en = 0; cyc();
    chk(stop_xfer, 0, "R9 idle"); chk(lock_in, 0, "R9 unlock");
    // R8 base equals fence: suppressed without interrupt
    drain_mode = 0; limit_code = 0;
    base_addr = 32'h1000; ptr = 32'h1000; cyc(2);
    chan_en = 1; cyc();
    chk(stop_xfer, 1, "R8 suppressed"); chk(fence_irq, 0, "R8 no irq");
    window_end = 1; cyc(); window_end = 0;
    chan_en = 0; cyc(2);
    // R1 mirrored comparison with negative pitch
    neg_pitch = 1; fence_addr = 32'h800; ptr = 32'h900; chan_en = 1; cyc(2);
    step_to(32'h880);
    chk(stop_xfer, 0, "R1 neg above fence runs");
    step_to(32'h800);
    chk(stop_xfer, 1, "R1 neg at fence stops"); chk(fence_irq, 1, "R2 neg irq");
    cyc(2);
    chan_en = 0; cyc(2);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule